// File: doc/BRIEF.md
# Parallel Gold Scrambling Code Generator

This block produces the complex downlink scrambling codes for a group of 16 neighbouring code numbers in parallel. The group is picked by a 9-bit group number S (0 to 511), and the codes in the group are n = 16·S through 16·S + 15. Each code is a Gold sequence built from two 18-stage maximal-length shift registers, x and y. For every chip the block presents 16 real bits and 16 imaginary bits at once, with bit b carrying code 16·S + b. A frame is 38400 chips.

The x register holds an 18-chip window of the x sequence. Its low 16 taps are XORed against the current y bit, so that one register step serves all 16 codes. The imaginary branch runs the same structure on x and y states that are 2^17 chips further along. Those states are fixed constants computed at elaboration time by raising the shift-register transition matrix to a power. After a start pulse the x registers of both branches step 16·S times, one step per cycle, to reach the group offset. Output then runs for one full frame, and a one-cycle done pulse follows it.

Top module: `gold_scr_gen`

## Requirements
- R1: While `chip_vld` is high at chip index i, `code_re[b]` equals x(i+16·S+b) XOR y(i) for b = 0..15. Here x(k+18) = x(k+7) XOR x(k) with x(0)=1 and x(1..17)=0, and y(k+18) = y(k+10) XOR y(k+7) XOR y(k+5) XOR y(k) with y(0..17)=1.
- R2: While `chip_vld` is high at chip index i, `code_im[b]` equals x(i+16·S+b+2^17) XOR y(i+2^17) for b = 0..15.
- R3: When `start` is sampled high, the first valid chip (i = 0) appears 16·S + 1 cycles after that clock edge, so it follows on the next cycle when S = 0. `chip_vld` stays low in between.
- R4: A frame is exactly 38400 consecutive cycles with `chip_vld` high, with no gap, and chip indices run 0 to 38399.
- R5: `done` is high for exactly one cycle, the cycle right after chip 38399, and `chip_vld` is low in that cycle.
- R6: A `start` sampled while a jump or a frame is in progress abandons it and restarts from chip 0 with the newly sampled S.
- R7: Whenever `chip_vld` is low, `code_re` and `code_im` are all zero. After reset, `chip_vld` and `done` are low.
- R8: `s_num` is sampled only in the cycle `start` is high. Changing it during a frame has no effect on the codes.
- R9: After `done`, the block stays idle with `chip_vld` low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new frame for group `s_num` |
| s_num | input | 9 | Group number S, codes 16·S..16·S+15 |
| chip_vld | output | 1 | High for each output chip of the frame |
| code_re | output | 16 | Real code bits, bit b is code 16·S+b |
| code_im | output | 16 | Imaginary code bits, bit b is code 16·S+b |
| done | output | 1 | One-cycle pulse after the last chip |

## Verification
If either branch starts from a wrong state, the fault shows up in the first valid chip. This covers a corrupted offset seed, a wrong tap, or a jump count that is off by one, and the effect spreads across all 16 output bits within a few chips as the window shifts. Errors in the jump counter or the chip counter show up as a wrong cycle count between `start` and the first `chip_vld`, or as a frame that ends early or late. Both of these are visible exactly at the cycle where they occur. Every chip of full frames for S = 0, 511 and 300, and of a frame cut short by a restart, is compared against a bit-serial model of the two sequences.

// File: rtl/gold_scr_pkg.sv
package gold_scr_pkg;

    localparam int LFSR_W      = 18;
    localparam int CODE_W      = 16;
    localparam int GROUP_W     = 9;
    localparam int GROUP_SHIFT = 4;
    localparam int IM_LOG2     = 17;
    localparam int FRAME_CHIPS = 38400;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [LFSR_W-1:0][LFSR_W-1:0] lfsr_mat_t;

    // bit j of a state holds sequence element (k + j)
    localparam lfsr_t X_TAPS = lfsr_t'((1 << 0) | (1 << 7));
    localparam lfsr_t Y_TAPS = lfsr_t'((1 << 0) | (1 << 5) | (1 << 7) | (1 << 10));
    localparam lfsr_t X_SEED = lfsr_t'(1);
    localparam lfsr_t Y_SEED = '1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_JUMP = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    function automatic lfsr_t lfsr_next(input lfsr_t s, input lfsr_t taps);
        return {^(s & taps), s[LFSR_W-1:1]};
    endfunction

    // state after 2**log2n steps, by repeated squaring of the transition matrix
    function automatic lfsr_t lfsr_leap(input lfsr_t seed, input lfsr_t taps, input int log2n);
        lfsr_mat_t m;
        lfsr_mat_t sq;
        lfsr_t     res;
        for (int r = 0; r < LFSR_W - 1; r++) begin
            m[r] = lfsr_t'(1) << (r + 1);
        end
        m[LFSR_W-1] = taps;
        for (int p = 0; p < log2n; p++) begin
            for (int r = 0; r < LFSR_W; r++) begin
                sq[r] = '0;
                for (int c = 0; c < LFSR_W; c++) begin
                    if (m[r][c]) sq[r] = sq[r] ^ m[c];
                end
            end
            m = sq;
        end
        for (int r = 0; r < LFSR_W; r++) begin
            res[r] = ^(m[r] & seed);
        end
        return res;
    endfunction

    localparam lfsr_t X_IM_SEED = lfsr_leap(X_SEED, X_TAPS, IM_LOG2);
    localparam lfsr_t Y_IM_SEED = lfsr_leap(Y_SEED, Y_TAPS, IM_LOG2);

endpackage

// File: rtl/gold_lfsr.sv
module gold_lfsr
    import gold_scr_pkg::*;
#(
    parameter lfsr_t TAPS = X_TAPS,
    parameter lfsr_t SEED = X_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  adv,
    output lfsr_t state
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state <= SEED;
        end else if (adv) begin
            state <= lfsr_next(state, TAPS);
        end
    end

    // a maximal-length register never falls into the all-zero lock state
    AST_STATE_LIVE: assert property (@(posedge clk) disable iff (rst)
        state != '0);                                              // R1

endmodule

// File: rtl/gold_seq_ctrl.sv
module gold_seq_ctrl
    import gold_scr_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_CHIPS,
    parameter int SEL_W     = GROUP_W,
    parameter int SHIFT     = GROUP_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] s_num,
    output logic             load,
    output logic             x_adv,
    output logic             y_adv,
    output logic             chip_vld,
    output logic             done
);

    localparam int JMP_W  = SEL_W + SHIFT;
    localparam int CHIP_W = $clog2(FRAME_LEN);
    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(FRAME_LEN - 1);

    phase_e             phase;
    logic [JMP_W-1:0]   jump_cnt;
    logic [CHIP_W-1:0]  chip_cnt;
    logic [JMP_W-1:0]   jump_init;

    assign jump_init = {s_num, {SHIFT{1'b0}}};
    assign load      = start;
    assign x_adv     = (phase == PH_JUMP) || (phase == PH_RUN);
    assign y_adv     = (phase == PH_RUN);
    assign chip_vld  = (phase == PH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            jump_cnt <= '0;
            chip_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                chip_cnt <= '0;
                jump_cnt <= jump_init;
                phase    <= (s_num == '0) ? PH_RUN : PH_JUMP;
            end else begin
                case (phase)
                    PH_JUMP: begin
                        jump_cnt <= jump_cnt - 1'b1;
                        if (jump_cnt == JMP_W'(1)) phase <= PH_RUN;
                    end
                    PH_RUN: begin
                        if (chip_cnt == LAST_CHIP) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            chip_cnt <= chip_cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    AST_JUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (start && s_num != '0) |=> !chip_vld);                     // R3
    AST_RUN_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (chip_vld && !start) |=> (chip_vld || done));               // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(chip_vld) && !chip_vld));                  // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                           // R5
    AST_STAY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!chip_vld && !start && phase == PH_IDLE) |=> !chip_vld);  // R9

endmodule

// File: rtl/gold_scr_gen.sv
module gold_scr_gen
    import gold_scr_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_CHIPS,
    parameter int SEL_W     = GROUP_W,
    parameter int OUT_W     = CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] s_num,
    output logic             chip_vld,
    output logic [OUT_W-1:0] code_re,
    output logic [OUT_W-1:0] code_im,
    output logic             done
);

    localparam int NBR = 2;   // branch 0 real, branch 1 imaginary
    localparam lfsr_t XSEEDS [NBR] = '{X_SEED, X_IM_SEED};
    localparam lfsr_t YSEEDS [NBR] = '{Y_SEED, Y_IM_SEED};

    logic             load;
    logic             x_adv;
    logic             y_adv;
    lfsr_t            xs    [NBR];
    lfsr_t            ys    [NBR];
    logic [OUT_W-1:0] words [NBR];

    gold_seq_ctrl #(
        .FRAME_LEN (FRAME_LEN),
        .SEL_W     (SEL_W),
        .SHIFT     ($clog2(OUT_W))
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .s_num    (s_num),
        .load     (load),
        .x_adv    (x_adv),
        .y_adv    (y_adv),
        .chip_vld (chip_vld),
        .done     (done)
    );

    for (genvar g = 0; g < NBR; g++) begin : g_branch
        gold_lfsr #(.TAPS(X_TAPS), .SEED(XSEEDS[g])) u_x (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .adv   (x_adv),
            .state (xs[g])
        );
        gold_lfsr #(.TAPS(Y_TAPS), .SEED(YSEEDS[g])) u_y (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .adv   (y_adv),
            .state (ys[g])
        );
        assign words[g] = chip_vld ? (xs[g][OUT_W-1:0] ^ {OUT_W{ys[g][0]}}) : '0;
    end

    assign code_re = words[0];
    assign code_im = words[1];

    // the two branches sit 2**17 chips apart, so their x windows never coincide
    AST_BRANCH_APART: assert property (@(posedge clk) disable iff (rst)
        xs[0] != xs[1]);                                           // R2

endmodule

// File: tb/tb_gold_scr_gen.sv
`timescale 1ns/1ps
module tb_gold_scr_gen;

    localparam int FRAME = 38400;
    localparam int NVEC  = 4;
    localparam int unsigned VEC_S [NVEC] = '{0, 511, 7, 300};
    localparam int unsigned VEC_N [NVEC] = '{FRAME, FRAME, 150, FRAME};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  s_num = '0;
    logic        chip_vld;
    logic [15:0] code_re;
    logic [15:0] code_im;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    logic [17:0] rx, ry, rxi, ryi, im_x0, im_y0;

    always #2 clk = ~clk;

    gold_scr_gen dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .s_num    (s_num),
        .chip_vld (chip_vld),
        .code_re  (code_re),
        .code_im  (code_im),
        .done     (done)
    );

    function automatic logic [17:0] bx_step(input logic [17:0] s);
        return {s[0] ^ s[7], s[17:1]};
    endfunction

    function automatic logic [17:0] by_step(input logic [17:0] s);
        return {s[0] ^ s[5] ^ s[7] ^ s[10], s[17:1]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run_frame(input int s, input int nchk);
        int lat;
        @(negedge clk);
        s_num = 9'(s);
        start = 1'b1;
        rx  = 18'h00001;
        ry  = 18'h3FFFF;
        rxi = im_x0;
        ryi = im_y0;
        for (int k = 0; k < 16 * s; k++) begin
            rx  = bx_step(rx);
            rxi = bx_step(rxi);
        end
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!chip_vld && lat < 9000) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 16 * s + 1, "R3/R6 start latency", 32'(lat), 32'(16 * s + 1));
        for (int c = 0; c < nchk; c++) begin
            chk(chip_vld == 1'b1, "R4 valid run", 32'(chip_vld), 32'd1);
            chk(code_re == (rx[15:0] ^ {16{ry[0]}}), "R1 real code", 32'(code_re),
                32'(rx[15:0] ^ {16{ry[0]}}));
            chk(code_im == (rxi[15:0] ^ {16{ryi[0]}}), "R2 imag code", 32'(code_im),
                32'(rxi[15:0] ^ {16{ryi[0]}}));
            rx  = bx_step(rx);
            ry  = by_step(ry);
            rxi = bx_step(rxi);
            ryi = by_step(ryi);
            if (c == 1000) s_num = 9'(s) ^ 9'h155;   // R8: ignored mid-frame
            @(negedge clk);
        end
        if (nchk == FRAME) begin
            chk(chip_vld == 1'b0, "R4 frame length", 32'(chip_vld), 32'd0);
            chk(done == 1'b1, "R5 done after last chip", 32'(done), 32'd1);
            @(negedge clk);
            chk(done == 1'b0, "R5 done single cycle", 32'(done), 32'd0);
            for (int w = 0; w < 16; w++) begin
                chk(chip_vld == 1'b0, "R9 idle after done", 32'(chip_vld), 32'd0);
                chk(code_re == '0 && code_im == '0, "R7 quiet outputs",
                    {code_re, code_im}, 32'd0);
                @(negedge clk);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<195000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        im_x0 = 18'h00001;
        im_y0 = 18'h3FFFF;
        for (int k = 0; k < (1 << 17); k++) begin
            im_x0 = bx_step(im_x0);
            im_y0 = by_step(im_y0);
        end
        repeat (3) @(negedge clk);
        chk(chip_vld == 1'b0, "R7 reset valid", 32'(chip_vld), 32'd0);
        chk(done == 1'b0, "R7 reset done", 32'(done), 32'd0);
        chk(code_re == '0 && code_im == '0, "R7 reset codes", {code_re, code_im}, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(chip_vld == 1'b0, "R9 idle before start", 32'(chip_vld), 32'd0);

        // table walk: the short entry is cut off by the next start (R6)
        for (int v = 0; v < NVEC; v++) begin
            run_frame(int'(VEC_S[v]), int'(VEC_N[v]));
        end

        // directed corner: first chip of group 0, codes 0 and 1
        run_frame(0, 0);
        chk(code_re[0] == 1'b0, "R1 S=0 code0 chip0", 32'(code_re[0]), 32'd0);
        chk(code_re[1] == 1'b1, "R1 S=0 code1 chip0", 32'(code_re[1]), 32'd1);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule